// File: doc/BRIEF.md
# Parallel Hamming-Accumulator Concatenated Encoder

This block turns a serial stream of data bits into frames of a serially concatenated code. It gathers incoming bits into 11-bit words. Each word is one lane of the frame and becomes a systematic (15,11) Hamming codeword. The 15 codeword bits are scrambled in two steps. The first step reorders the bits inside each codeword. The second step spreads each bit position across the frame. Fifteen two-state rate-1 accumulators then run over the scrambled rows. Each output beat carries one bit from every accumulator, all at the same row index, and is ready for a symbol mapper.

A frame holds `NCW` codewords, so it takes `11*NCW` input bits and gives `NCW` output beats of 15 bits. Both permutations are affine maps of the form `(a*i + b) mod N`. The scrambling is done while the codeword is stored. The read side therefore walks its storage in order.

Storage is double-buffered. One frame can fill while the previous one drains. Input flow control: a bit moves on a cycle with `in_valid` and `in_ready` both high, and `in_ready` drops only while both buffers hold frames that are not yet read. Output flow control: a beat moves on a cycle with `out_valid` and `out_ready` both high. While a beat is stalled it stays unchanged.

Top module: `hac_encoder`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Bits are taken 11 at a time, and the first bit received becomes data bit 0. The codeword is systematic. Bits 0..10 equal the data bits. Parity bit 11+i is the XOR of each data bit j whose column value has bit i set. The columns for data bits 0..10 are the 4-bit values of weight two or more, in ascending order: 3,5,6,7,9,10,11,12,13,14,15.
- R3: First scrambling step. Take codeword c of a frame, with c counted from 0 in arrival order. Its scrambled bit j equals codeword bit (7*j + c) mod 15.
- R4: Second scrambling step. Scrambled bit j of codeword c goes to row j at index (`PERM2_A`*c + j) mod `NCW`.
- R5: At output beat k, `out_bits[j]` equals row j, index k, XOR `out_bits[j]` of beat k-1 of the same frame. Before beat 0 of every frame that previous value is taken as 0.
- R6: Each frame gives exactly `NCW` beats in a row. Beats are in index order, and frames keep their input order. `out_first` is high on beat 0 and `out_last` is high on beat `NCW`-1.
- R7: `out_valid` goes high on the cycle after the last bit of a frame is accepted, provided no earlier frame is waiting.
- R8: `in_ready` is low only when two complete frames are unread. It returns high on the cycle after the last beat of a frame is taken. Bits offered while it is low are not taken.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bits`, `out_first` and `out_last` hold their values.
- R10: Suppose the last input bit of one frame and the last output beat of another frame are accepted in the same cycle. Then both take effect: the next cycle shows beat 0 of the newer frame, with `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Block can accept a bit |
| in_bit | input | 1 | Serial data bit |
| out_valid | output | 1 | Coded beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_bits | output | 15 | One accumulator output per row |
| out_first | output | 1 | Beat 0 of a frame |
| out_last | output | 1 | Final beat of a frame |

## Verification
Two events can land on the same clock edge. One is the fill side finishing a frame: it marks one buffer full and swaps write buffers. The other is the drain side finishing a frame: it frees the other buffer and swaps read buffers. To provoke this, the bench fills one buffer and lets it wait. It then sends all but the last bit of a further frame and drains all but the last beat of the waiting one. Finally it drives the missing bit and the last beat on the same cycle. The result is judged on the next cycle. Beat 0 of the newer frame must appear with its own expected bits and `out_first` set, and `in_ready` must be high. The newer frame must then drain completely and correctly.

// File: rtl/hac_pkg.sv
package hac_pkg;
  localparam int CW_N    = 15;
  localparam int CW_K    = 11;
  localparam int CW_P    = CW_N - CW_K;
  localparam int PERM1_A = 7;

  // Column of the parity matrix for data bit j: the j-th 4-bit value of weight >= 2
  function automatic logic [3:0] par_col(input int j);
    logic [3:0] r;
    int n;
    r = '0;
    n = 0;
    for (int v = 3; v < 16; v++) begin
      if ($countones(4'(v)) > 1) begin
        if (n == j) r = 4'(v);
        n++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/hac_ham_enc.sv
module hac_ham_enc
  import hac_pkg::*;
(
  input  logic [CW_K-1:0] data,
  output logic [CW_N-1:0] cw
);
  assign cw[CW_K-1:0] = data;

  for (genvar i = 0; i < CW_P; i++) begin : g_par
    always_comb begin
      logic       p;
      logic [3:0] col;
      p = 1'b0;
      for (int j = 0; j < CW_K; j++) begin
        col = par_col(j);
        if (col[i]) p = p ^ data[j];
      end
      cw[CW_K+i] = p;
    end
  end
endmodule

// File: rtl/hac_cw_perm.sv
module hac_cw_perm
  import hac_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic [IW-1:0]   cw_idx,
  input  logic [CW_N-1:0] cw,
  output logic [CW_N-1:0] pcw
);
  for (genvar j = 0; j < CW_N; j++) begin : g_bit
    always_comb begin
      logic [3:0] src;
      src    = 4'((PERM1_A * j + int'(cw_idx)) % CW_N);
      pcw[j] = cw[src];
    end
  end
endmodule

// File: rtl/hac_ilv_buf.sv
module hac_ilv_buf
  import hac_pkg::*;
#(
  parameter int NCW     = 12,
  parameter int PERM2_A = 5,
  parameter int IW      = (NCW > 1) ? $clog2(NCW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CW_N-1:0] wr_bits,
  output logic [IW-1:0]   wr_idx,
  output logic            wr_ok,
  input  logic            rd_take,
  output logic            rd_valid,
  output logic [CW_N-1:0] rd_bits,
  output logic            rd_first,
  output logic            rd_last
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NCW - 1);

  logic [NCW-1:0] mem [2][CW_N];
  logic [1:0]     full;
  logic           wb, rb;
  logic [IW-1:0]  wcnt, rk;
  logic [IW-1:0]  wpos [CW_N];

  for (genvar j = 0; j < CW_N; j++) begin : g_pos
    assign wpos[j]    = IW'((PERM2_A * int'(wcnt) + j) % NCW);
    assign rd_bits[j] = mem[rb][j][rk];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int j = 0; j < CW_N; j++) mem[wb][j][wpos[j]] <= wr_bits[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= '0;
      wb   <= 1'b0;
      rb   <= 1'b0;
      wcnt <= '0;
      rk   <= '0;
    end else begin
      if (wr_en) begin
        if (wcnt == LAST_IDX) begin
          wcnt     <= '0;
          full[wb] <= 1'b1;
          wb       <= ~wb;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
      if (rd_take) begin
        if (rk == LAST_IDX) begin
          rk       <= '0;
          full[rb] <= 1'b0;
          rb       <= ~rb;
        end else begin
          rk <= rk + 1'b1;
        end
      end
    end
  end

  assign wr_idx   = wcnt;
  assign wr_ok    = ~full[wb];
  assign rd_valid = full[rb];
  assign rd_first = (rk == '0);
  assign rd_last  = (rk == LAST_IDX);
endmodule

// File: rtl/hac_acc_lanes.sv
module hac_acc_lanes #(
  parameter int LANES = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [LANES-1:0] x,
  output logic [LANES-1:0] y
);
  for (genvar j = 0; j < LANES; j++) begin : g_acc
    logic st;
    assign y[j] = (first ? 1'b0 : st) ^ x[j];
    always_ff @(posedge clk) begin
      if (!rst_n)    st <= 1'b0;
      else if (take) st <= y[j];
    end
  end
endmodule

// File: rtl/hac_encoder.sv
module hac_encoder
  import hac_pkg::*;
#(
  parameter int NCW     = 12,
  parameter int PERM2_A = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_bit,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [14:0] out_bits,
  output logic        out_first,
  output logic        out_last
);
  localparam int IW = (NCW > 1) ? $clog2(NCW) : 1;
  localparam logic [3:0] BIT_LAST = 4'(CW_K - 1);

  logic [CW_K-2:0] dbuf;
  logic [3:0]      bcnt;
  logic            accept, wr_en, rd_take, wr_ok, rd_first, rd_valid;
  logic [CW_K-1:0] dword;
  logic [CW_N-1:0] cw, pcw, rd_bits;
  logic [IW-1:0]   wr_idx;

  assign in_ready = wr_ok;
  assign accept   = in_valid & in_ready;
  assign wr_en    = accept & (bcnt == BIT_LAST);
  assign dword    = {in_bit, dbuf};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= '0;
      dbuf <= '0;
    end else if (accept) begin
      dbuf <= {in_bit, dbuf[CW_K-2:1]};
      bcnt <= (bcnt == BIT_LAST) ? 4'd0 : bcnt + 4'd1;
    end
  end

  hac_ham_enc u_ham (.data(dword), .cw(cw));

  hac_cw_perm #(.IW(IW)) u_perm1 (.cw_idx(wr_idx), .cw(cw), .pcw(pcw));

  hac_ilv_buf #(.NCW(NCW), .PERM2_A(PERM2_A), .IW(IW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_bits(pcw), .wr_idx(wr_idx), .wr_ok(wr_ok),
    .rd_take(rd_take), .rd_valid(rd_valid), .rd_bits(rd_bits),
    .rd_first(rd_first), .rd_last(out_last)
  );

  assign out_valid = rd_valid;
  assign out_first = rd_first;
  assign rd_take   = rd_valid & out_ready;

  hac_acc_lanes #(.LANES(CW_N)) u_acc (
    .clk(clk), .rst_n(rst_n), .take(rd_take), .first(rd_first),
    .x(rd_bits), .y(out_bits)
  );
endmodule

// File: rtl/hac_enc_chk.sv
module hac_enc_chk #(
  parameter int NCW = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [14:0] out_bits,
  input logic        out_first,
  input logic        out_last
);
  localparam int IW = (NCW > 1) ? $clog2(NCW) : 1;
  logic [IW-1:0] beat;

  always_ff @(posedge clk) begin
    if (!rst_n) beat <= '0;
    else if (out_valid && out_ready) beat <= (beat == IW'(NCW - 1)) ? '0 : beat + 1'b1;
  end

  // R6
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_first == (beat == '0)));
  // R6
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (beat == IW'(NCW - 1))));
  // R6
  frame_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bits) && $stable(out_first) && $stable(out_last)));
  // R8
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);
  // R8
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> in_ready);
endmodule

bind hac_encoder hac_enc_chk #(.NCW(NCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_bits(out_bits), .out_first(out_first), .out_last(out_last)
);

// File: tb/test_hac_encoder.sv
module test_hac_encoder;
  localparam int NCW = 6;
  localparam int A2  = 5;
  localparam int NF  = 6;
  localparam logic [10:0] WORDS [12] = '{11'h000, 11'h7FF, 11'h001, 11'h400, 11'h555, 11'h2AA,
                                         11'h123, 11'h6DB, 11'h0F0, 11'h70F, 11'h3C3, 11'h18E};
  localparam logic [3:0] COLS [11] = '{4'd3, 4'd5, 4'd6, 4'd7, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_first, out_last;
  logic [14:0] out_bits;
  int checks = 0, errors = 0;
  logic [14:0] expv [NF][NCW];

  always #5 clk = ~clk;

  hac_encoder #(.NCW(NCW), .PERM2_A(A2)) i_hac_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits),
    .out_first(out_first), .out_last(out_last)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] word_of(input int f, input int c);
    return WORDS[(f * 5 + c) % 12];
  endfunction

  // R2 reference encoder
  function automatic logic [14:0] henc(input logic [10:0] d);
    logic [14:0] cw;
    cw[10:0] = d;
    for (int i = 0; i < 4; i++) begin
      logic p;
      p = 1'b0;
      for (int j = 0; j < 11; j++) if (COLS[j][i]) p = p ^ d[j];
      cw[11+i] = p;
    end
    return cw;
  endfunction

  task automatic build_exp(input int f);
    logic [NCW-1:0] rows [15];
    logic [14:0] cw, st;
    for (int c = 0; c < NCW; c++) begin
      cw = henc(word_of(f, c));
      for (int j = 0; j < 15; j++) rows[j][(A2 * c + j) % NCW] = cw[(7 * j + c) % 15]; // R3, R4
    end
    st = '0;
    for (int k = 0; k < NCW; k++) begin
      for (int j = 0; j < 15; j++) st[j] = st[j] ^ rows[j][k]; // R5
      expv[f][k] = st;
    end
  endtask

  task automatic send_frame(input int f, input bit hold_last, input bit idle);
    for (int c = 0; c < NCW; c++) begin
      for (int i = 0; i < 11; i++) begin
        bit fin;
        fin = (c == NCW - 1) && (i == 10);
        if (!(hold_last && fin)) begin
          logic [10:0] w;
          w = word_of(f, c);
          @(negedge clk);
          in_valid = 1'b1;
          in_bit   = w[i];
          while (!in_ready) @(negedge clk);
          if (idle && fin) check("R7 valid before last bit", 32'(out_valid), 32'd0);
          @(posedge clk);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (idle && !hold_last) check("R7 valid after last bit", 32'(out_valid), 32'd1);
  endtask

  task automatic drain(input int f, input int nbeats, input bit stall);
    for (int k = 0; k < nbeats; k++) begin
      @(negedge clk);
      out_ready = 1'b0;
      if (stall && k == 2) begin
        for (int s = 0; s < 3; s++) begin
          @(posedge clk);
          @(negedge clk);
          check("R9 held beat", {15'd0, out_valid, out_first, out_last, out_bits},
                {15'd0, 1'b1, 1'b0, 1'b0, expv[f][k]});
        end
      end
      out_ready = 1'b1;
      check("R6 beat valid", 32'(out_valid), 32'd1);
      check("R5 beat bits", 32'(out_bits), 32'(expv[f][k]));
      check("R6 first/last", {30'd0, out_first, out_last}, {30'd0, k == 0, k == NCW - 1});
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int f = 0; f < NF; f++) build_exp(f);
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", 32'(in_ready), 32'd1);
    check("R1 valid", 32'(out_valid), 32'd0);

    // table walk: frames built from the word table, each sent then drained (R2..R7)
    for (int f = 0; f < 3; f++) begin
      send_frame(f, 1'b0, 1'b1);
      drain(f, NCW, f == 1);
      check("R6 idle after frame", {30'd0, in_ready, out_valid}, {30'd0, 1'b1, 1'b0});
    end

    // both buffers full: R8
    send_frame(3, 1'b0, 1'b1);
    send_frame(4, 1'b0, 1'b0);
    check("R8 ready low when both full", 32'(in_ready), 32'd0);
    in_valid = 1'b1;
    in_bit   = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 still low", 32'(in_ready), 32'd0);
    in_valid = 1'b0;
    drain(3, NCW, 1'b0);
    check("R8 ready back", 32'(in_ready), 32'd1);
    check("R6 next frame first", {30'd0, out_valid, out_first}, {30'd0, 1'b1, 1'b1});

    // R10: fill end and drain end on one edge
    send_frame(5, 1'b1, 1'b0);
    drain(4, NCW - 1, 1'b0);
    begin
      logic [10:0] w;
      w = word_of(5, NCW - 1);
      @(negedge clk);
      in_valid  = 1'b1;
      in_bit    = w[10];
      out_ready = 1'b1;
      check("R10 last beat old frame", {16'd0, out_last, out_bits}, {16'd0, 1'b1, expv[4][NCW-1]});
      @(posedge clk);
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b0;
      check("R10 new frame visible", {29'd0, out_valid, out_first, in_ready}, {29'd0, 1'b1, 1'b1, 1'b1});
      check("R10 new frame beat0", 32'(out_bits), 32'(expv[5][0]));
    end
    drain(5, NCW, 1'b0);
    check("R6 idle at end", {30'd0, in_ready, out_valid}, {30'd0, 1'b1, 1'b0});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule